// File: doc/BRIEF.md
# MESI Line State Controller

This block tracks the coherence state of a single data-cache line and decides, for each access presented to it, the line's next state and whether the access needs an external bus cycle. The state is one of Modified, Exclusive, Shared or Invalid, held in a register. The access type, a per-cycle policy pin driven by the system, a per-page write-through bit and a snoop invalidate flag are the inputs. The line data and the bus protocol timing are handled elsewhere.

The policy pin selects write-back (1) or write-through (0) for each cycle. When a system ties it to its write/read strobe, the block gives write-once behaviour: the first store to a shared line goes through to memory, and later stores stay in the cache. A set page write-through bit makes the pin count as 0. Snoop inquiries report a hit and a modified hit on two active-low outputs. When the line is modified, the snoop raises a write-back request. A parameter builds an instruction-side variant that only uses the Shared and Invalid states.

Top module: `mesi_line_ctrl`

## Requirements
- R1: While reset is held, and for the synchronised release that follows it, the line is Invalid (state code 0). In that period wr_thru_o and wr_back_o are 0 and hit_n_o and hitm_n_o are 1. State codes are I=0, S=1, E=2 and M=3.
- R2: A fill (op 1) to an Invalid line enters E when wb_pin_i=1 and page_wt_i=0, and enters S otherwise. A fill to a line that is already valid leaves the line unchanged.
- R3: A store (op 2) to a line in S raises wr_thru_o. The line moves to E when wb_pin_i=1 and page_wt_i=0, and stays in S otherwise. This is the write-once path.
- R4: A store to a line in E moves it to M, and a store to a line in M leaves it in M. Neither raises a bus request, whatever the value of page_wt_i.
- R5: A store to an Invalid line raises wr_thru_o and leaves the line Invalid, so no line is allocated.
- R6: A locked store (op 3) always raises wr_thru_o and leaves the state unchanged. A line in M stays in M.
- R7: A replacement (op 4) moves any state to I. It raises wr_back_o only when the line was in M.
- R8: During a snoop (op 5), hit_n_o is 0 exactly when the line is valid, and hitm_n_o is 0 exactly when the line is in M. Outside a snoop, both are 1.
- R9: A snoop with snp_inv_i=1 moves any state to I. A snoop with snp_inv_i=0 moves E and M to S and leaves S unchanged. A snoop of a line in M raises wr_back_o.
- R10: With ICACHE=1, fills always enter S, stores and locked stores change nothing and request no bus cycle, E and M are never reached, and hitm_n_o stays 1.
- R11: No-op (op 0) and the unused codes 6 and 7 leave the state unchanged and keep every output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Access type: 0 none, 1 fill, 2 store, 3 locked store, 4 replace, 5 snoop |
| wb_pin_i | input | 1 | Per-cycle policy: 1 write-back, 0 write-through |
| page_wt_i | input | 1 | Page write-through bit; overrides wb_pin_i |
| snp_inv_i | input | 1 | Snoop requests invalidation |
| state_o | output | 2 | Current line state (I=0, S=1, E=2, M=3) |
| wr_thru_o | output | 1 | The store must be issued on the bus |
| wr_back_o | output | 1 | The modified line must be written back |
| hit_n_o | output | 1 | Snoop hit, active low |
| hitm_n_o | output | 1 | Snoop hit on modified line, active low |

## Verification
The bench walks the write-once path, fill S then store then E then store then M. A design that ignored the policy pin on the S store would stay in S and keep writing through. It also stores to E and M lines with the page write-through bit set: a design that let the bit override cache state would raise wr_thru_o. It runs locked stores on an M line, where a design that downgraded the line would lose its dirty data. It sends non-invalidating snoops to M, where a missing wr_back_o, or a line left in M, would both show at the ports. Long mixed sequences, including the unused op codes, run on both the data and the instruction variants against a reference model.

// File: rtl/mlc_pkg.sv
`timescale 1ns/1ps
package mlc_pkg;
  localparam int ST_W = 2;
  localparam int OP_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_FILL = 3'd1,
    OP_WR   = 3'd2,
    OP_LKWR = 3'd3,
    OP_RPL  = 3'd4,
    OP_SNP  = 3'd5
  } line_op_e;
endpackage

// File: rtl/mlc_rst_sync.sv
`timescale 1ns/1ps
module mlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/mlc_next.sv
`timescale 1ns/1ps
module mlc_next
  import mlc_pkg::*;
#(
  parameter bit ICACHE = 1'b0
) (
  input  line_st_e cur_i,
  input  line_op_e op_i,
  input  logic     wb_pin_i,
  input  logic     page_wt_i,
  input  logic     snp_inv_i,
  output line_st_e nxt_o,
  output logic     wr_thru_o,
  output logic     wr_back_o
);
  localparam bit WRITABLE = !ICACHE;

  logic keep_wb;
  assign keep_wb = wb_pin_i & ~page_wt_i;

  always_comb begin
    nxt_o     = cur_i;
    wr_thru_o = 1'b0;
    wr_back_o = 1'b0;
    case (op_i)
      OP_FILL: begin
        if (cur_i == ST_I) nxt_o = (keep_wb && WRITABLE) ? ST_E : ST_S;
      end
      OP_WR: begin
        if (WRITABLE) begin
          case (cur_i)
            ST_I: wr_thru_o = 1'b1;
            ST_S: begin
              wr_thru_o = 1'b1;
              nxt_o     = keep_wb ? ST_E : ST_S;
            end
            ST_E: nxt_o = ST_M;
            default: nxt_o = ST_M;
          endcase
        end
      end
      OP_LKWR: begin
        if (WRITABLE) wr_thru_o = 1'b1;
      end
      OP_RPL: begin
        nxt_o     = ST_I;
        wr_back_o = (cur_i == ST_M);
      end
      OP_SNP: begin
        if (cur_i != ST_I) nxt_o = snp_inv_i ? ST_I : ST_S;
        wr_back_o = (cur_i == ST_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mlc_snoop.sv
`timescale 1ns/1ps
module mlc_snoop
  import mlc_pkg::*;
#(
  parameter bit ICACHE = 1'b0
) (
  input  line_st_e cur_i,
  input  line_op_e op_i,
  output logic     hit_n_o,
  output logic     hitm_n_o
);
  logic is_snp;
  assign is_snp  = (op_i == OP_SNP);
  assign hit_n_o = ~(is_snp && (cur_i != ST_I));

  generate
    if (ICACHE) begin : g_ic
      assign hitm_n_o = 1'b1;
    end else begin : g_dc
      assign hitm_n_o = ~(is_snp && (cur_i == ST_M));
    end
  endgenerate
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mlc_pkg::*;
#(
  parameter bit ICACHE      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic            wb_pin_i,
  input  logic            page_wt_i,
  input  logic            snp_inv_i,
  output logic [ST_W-1:0] state_o,
  output logic            wr_thru_o,
  output logic            wr_back_o,
  output logic            hit_n_o,
  output logic            hitm_n_o
);
  logic     rst_q_n;
  line_op_e op;
  line_st_e st_q, st_d;
  logic     st_en;
  logic     thru, back;

  assign op = line_op_e'(op_i);

  mlc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  mlc_next #(.ICACHE(ICACHE)) u_next (
    .cur_i(st_q), .op_i(op), .wb_pin_i(wb_pin_i), .page_wt_i(page_wt_i),
    .snp_inv_i(snp_inv_i), .nxt_o(st_d), .wr_thru_o(thru), .wr_back_o(back)
  );

  mlc_snoop #(.ICACHE(ICACHE)) u_snp (
    .cur_i(st_q), .op_i(op), .hit_n_o(hit_n_o), .hitm_n_o(hitm_n_o)
  );

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   st_q <= ST_I;
    else if (st_en) st_q <= st_d;
  end

  assign state_o   = st_q;
  assign wr_thru_o = thru & rst_q_n;
  assign wr_back_o = back & rst_q_n;

  // R4: a dirty line stays dirty across an ordinary store
  p_m_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st_q == ST_M && op == OP_WR) |=> (st_q == ST_M));

  // R6: locked store goes to the bus and keeps the state
  p_lock_bus_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_LKWR && !ICACHE) |-> wr_thru_o);
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_LKWR) |=> (st_q == $past(st_q)));

  // R7: replacement always empties the line
  p_rpl_inv_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_RPL) |=> (st_q == ST_I));

  // R8: a modified hit is always also a hit
  p_hitm_implies_hit_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !hitm_n_o |-> !hit_n_o);

  // R9: invalidating snoop empties the line; plain snoop never leaves it exclusive
  p_snp_inv_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_SNP && snp_inv_i) |=> (st_q == ST_I));
  p_snp_share_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op == OP_SNP && !snp_inv_i) |=> (st_q == ST_I || st_q == ST_S));

  // R10: instruction variant never owns a line
  p_ic_states_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ICACHE |-> (st_q == ST_I || st_q == ST_S));
endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic       pin = 1'b0, wt = 1'b0, inv = 1'b0;
  logic [1:0] d_st, i_st;
  logic       d_thru, d_back, d_hn, d_hmn;
  logic       i_thru, i_back, i_hn, i_hmn;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int ref_d = 0, ref_i = 0;

  always #4 clk = ~clk;

  mesi_line_ctrl #(.ICACHE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .wb_pin_i(pin), .page_wt_i(wt),
    .snp_inv_i(inv), .state_o(d_st), .wr_thru_o(d_thru), .wr_back_o(d_back),
    .hit_n_o(d_hn), .hitm_n_o(d_hmn));

  mesi_line_ctrl #(.ICACHE(1'b1)) u_dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .wb_pin_i(pin), .page_wt_i(wt),
    .snp_inv_i(inv), .state_o(i_st), .wr_thru_o(i_thru), .wr_back_o(i_back),
    .hit_n_o(i_hn), .hitm_n_o(i_hmn));

  // behavioural reference: states 0=I 1=S 2=E 3=M
  task automatic model(input int st, input int o, input bit p, input bit w,
                       input bit iv, input bit ic, output int nx, output bit th,
                       output bit bk, output bit hn, output bit hmn);
    bit wb;
    wb = p && !w;
    nx = st; th = 0; bk = 0; hn = 1; hmn = 1;
    if (o == 1 && st == 0) nx = (wb && !ic) ? 2 : 1;
    if (o == 2 && !ic) begin
      if (st == 0) th = 1;
      else if (st == 1) begin th = 1; nx = wb ? 2 : 1; end
      else nx = 3;
    end
    if (o == 3 && !ic) th = 1;
    if (o == 4) begin bk = (st == 3); nx = 0; end
    if (o == 5) begin
      hn  = (st == 0);
      hmn = !(st == 3 && !ic);
      bk  = (st == 3);
      if (st != 0) nx = iv ? 0 : 1;
    end
  endtask

  function automatic string tag(int o, int st, bit ic);
    if (ic) return "R10";
    case (o)
      1: return "R2";
      2: return (st == 0) ? "R5" : (st == 1) ? "R3" : "R4";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(string r, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic check_one(bit ic, int st_ref, int o, output int nx);
    bit th, bk, hn, hmn;
    string r;
    model(st_ref, o, pin, wt, inv, ic, nx, th, bk, hn, hmn);
    r = tag(o, st_ref, ic);
    if (!ic) begin
      cmp(r, "state", d_st, st_ref);
      cmp(r, "wr_thru", d_thru, th);
      cmp(r, "wr_back", d_back, bk);
      cmp("R8", "hit_n", d_hn, hn);
      cmp("R8", "hitm_n", d_hmn, hmn);
    end else begin
      cmp(r, "state", i_st, st_ref);
      cmp(r, "wr_thru", i_thru, th);
      cmp(r, "wr_back", i_back, bk);
      cmp("R10", "hit_n", i_hn, hn);
      cmp("R10", "hitm_n", i_hmn, hmn);
    end
  endtask

  task automatic step(int o, bit p, bit w, bit iv);
    int nd, ni;
    @(negedge clk);
    op = 3'(o); pin = p; wt = w; inv = iv;
    #1;
    check_one(1'b0, ref_d, o, nd);
    check_one(1'b1, ref_i, o, ni);
    @(posedge clk);
    ref_d = nd; ref_i = ni;
  endtask

  task automatic check_reset();
    #1;
    cmp("R1", "state", d_st, 0);
    cmp("R1", "wr_thru", d_thru, 0);
    cmp("R1", "wr_back", d_back, 0);
    cmp("R1", "hit_n", d_hn, 1);
    cmp("R1", "hitm_n", d_hmn, 1);
    cmp("R1", "ic state", i_st, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    // a snoop during reset must not report a hit
    op = 3'd5;
    check_reset();
    op = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_reset();

    // write-once path, R2 R3 R4
    step(1, 0, 0, 0);  // fill S
    step(2, 1, 0, 0);  // S store, write through, to E
    step(2, 1, 0, 0);  // E to M silently
    step(2, 0, 1, 0);  // M store with page WT: no bus
    step(3, 0, 0, 0);  // R6 locked store on M
    step(1, 1, 0, 0);  // fill on valid line ignored
    step(5, 0, 0, 0);  // R9 snoop M no-inv: write-back, to S
    step(2, 0, 0, 0);  // S store pin 0 stays S
    step(2, 1, 1, 0);  // page WT forces S
    step(6, 1, 0, 1);  // R11 unused code
    step(5, 0, 0, 1);  // snoop inv S to I
    step(2, 1, 0, 0);  // R5 miss
    step(1, 1, 0, 0);  // fill E
    step(2, 1, 1, 0);  // E store with page WT: M no bus
    step(4, 0, 0, 0);  // R7 replace M
    step(1, 1, 1, 0);  // fill with WT to S
    step(4, 0, 0, 0);  // replace S
    step(1, 1, 0, 0);
    step(5, 0, 0, 0);  // snoop E to S
    step(0, 1, 1, 1);
    step(7, 1, 1, 1);

    for (int k = 0; k < 4000; k++)
      step($urandom_range(0, 7), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule